// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave-side register port controlled over four wires: a frame enable, a serial clock, a serial data input and a serial data output. The host raises the enable and clocks in a command bit, a 9-bit register address and a data word, all most-significant bit first. The block then either updates a small internal register bank or shifts the addressed register's contents back out on the data output. Both happen inside the same enable-framed transaction.

The four serial pins are oversampled by the block's own system clock. A write takes effect only when the frame closes, so a host can send fewer data bits than the register width. The bits it omits at the top of the register are filled with zeros. The bank holds four 28-bit registers at addresses 0x1C0 to 0x1C3. An active-low reset returns every register to its default value.

Top module: `ser_reg_port`

## Requirements
- R1: While rst_n is low at a rising clk edge, every register loads its default value 0x50 + i, where i is its index. Register i lives at address 0x1C0 + i, for i = 0 to 3.
- R2: The frame format is fixed. While ser_en is high, ser_din is sampled on each rising edge of ser_clk. The first bit is the command (0 = write, 1 = read). The next 9 bits are the address, MSB first. Any further bits are data, MSB first.
- R3: A write frame carrying exactly 28 data bits stores that word in the addressed register when ser_en falls.
- R4: A write frame carrying N < 28 data bits stores the N-bit value received, with all upper bits zero. With N = 0 the register is cleared.
- R5: Data bits after the 28th in a write frame are ignored; the first 28 bits received are stored.
- R6: A frame that ends before the command and all 9 address bits are received has no effect on any register.
- R7: In a read frame, ser_dout presents the addressed register MSB first. It is updated on each falling edge of ser_clk, starting with the falling edge that follows the last address bit. After all 28 bits have been shifted out, ser_dout is low.
- R8: ser_dout is low whenever no read data is being presented: in reset, between frames, during a header and throughout a write frame.
- R9: A write to an address outside 0x1C0 to 0x1C3 changes no register. A read from such an address returns all zeros.
- R10: A read frame leaves the addressed register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset; loads register defaults |
| ser_clk | input | 1 | Serial clock from the host |
| ser_en | input | 1 | Frame enable, high for the length of a transaction |
| ser_din | input | 1 | Serial command, address and write data |
| ser_dout | output | 1 | Serial read data |

## Verification
A wrong bit count or a stale address would show up as a wrong value in a later read-back frame. Because of that, every write is followed by a read, so such an error surfaces within about 40 serial clock periods. A wrong shift-out state would show at ser_dout on the very next falling edge of ser_clk. The bench catches it either as a bit in the wrong position or as a high level outside the read data window. Reset and abort faults are exposed by reading the whole bank back and comparing it with a model that the bench keeps.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int ADDR_W    = 9;
    localparam int DATA_W    = 28;
    localparam int REG_COUNT = 4;
    localparam logic [ADDR_W-1:0] BANK_BASE = 9'h1C0;

    localparam int HDR_BITS  = 1 + ADDR_W;
    localparam int FRAME_MAX = HDR_BITS + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic {
        CMD_WRITE = 1'b0,
        CMD_READ  = 1'b1
    } cmd_e;

    // Events derived from the oversampled serial pins
    typedef struct packed {
        logic rise;
        logic fall;
        logic en;
        logic en_fell;
        logic din;
    } pin_evt_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        return DATA_W'(32'h50 + idx);
    endfunction
endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync
    import ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk,
    input  logic     sen,
    input  logic     sdi,
    output pin_evt_t evt
);
    logic [1:0] clk_pipe;
    logic [1:0] en_pipe;
    logic       din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            en_pipe  <= '0;
            din_q    <= 1'b0;
        end else begin
            clk_pipe <= {clk_pipe[0], sclk};
            en_pipe  <= {en_pipe[0], sen};
            din_q    <= sdi;
        end
    end

    always_comb begin
        evt.rise    = clk_pipe[0] & ~clk_pipe[1];
        evt.fall    = ~clk_pipe[0] & clk_pipe[1];
        evt.en      = en_pipe[0];
        evt.en_fell = ~en_pipe[0] & en_pipe[1];
        evt.din     = din_q;
    end
endmodule

// File: rtl/ser_frame.sv
module ser_frame
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pin_evt_t          evt,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sdo
);
    cmd_e              cmd;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] shout;
    logic              rd_active;
    logic              sdo_q;
    logic [CNT_W-1:0]  cnt;
    logic              take;

    assign take    = evt.en & evt.rise;
    assign rd_addr = {addr_q[ADDR_W-2:0], evt.din};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd       <= CMD_WRITE;
            addr_q    <= '0;
            data_q    <= '0;
            shout     <= '0;
            rd_active <= 1'b0;
            sdo_q     <= 1'b0;
            cnt       <= '0;
        end else if (!evt.en) begin
            cnt       <= '0;
            data_q    <= '0;
            rd_active <= 1'b0;
            sdo_q     <= 1'b0;
        end else begin
            if (take) begin
                if (cnt == '0) begin
                    cmd <= cmd_e'(evt.din);
                end else if (cnt <= CNT_W'(ADDR_W)) begin
                    addr_q <= rd_addr;
                end else if (cnt < CNT_W'(FRAME_MAX)) begin
                    data_q <= {data_q[DATA_W-2:0], evt.din};
                end
                if (cnt < CNT_W'(FRAME_MAX)) begin
                    cnt <= cnt + 1'b1;
                end
                if (cnt == CNT_W'(ADDR_W) && cmd == CMD_READ) begin
                    rd_active <= 1'b1;
                    shout     <= rd_word;
                end
            end
            if (evt.fall && rd_active) begin
                sdo_q <= shout[DATA_W-1];
                shout <= {shout[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign wr_en   = evt.en_fell && (cmd == CMD_WRITE) && (cnt >= CNT_W'(HDR_BITS));
    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign bit_cnt = cnt;
    assign sdo     = sdo_q;
endmodule

// File: rtl/ser_bank.sv
module ser_bank
    import ser_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_word,
    output logic [REG_COUNT-1:0][DATA_W-1:0]  regs
);
    logic [REG_COUNT-1:0] wr_hit;
    logic [REG_COUNT-1:0] rd_hit;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_dec
        assign wr_hit[g] = (wr_addr == BANK_BASE + ADDR_W'(g));
        assign rd_hit[g] = (rd_addr == BANK_BASE + ADDR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_COUNT; i++) begin
            if (!rst_n) begin
                regs[i] <= reg_default(i);
            end else if (wr_en && wr_hit[i]) begin
                regs[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_hit[i]) begin
                rd_word = regs[i];
            end
        end
    end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_en,
    input  logic ser_din,
    output logic ser_dout
);
    pin_evt_t                         evt;
    logic [DATA_W-1:0]                rd_word;
    logic [ADDR_W-1:0]                rd_addr;
    logic                             wr_en;
    logic [ADDR_W-1:0]                wr_addr;
    logic [DATA_W-1:0]                wr_data;
    logic [CNT_W-1:0]                 bit_cnt;
    logic [REG_COUNT-1:0][DATA_W-1:0] regs;

    ser_pin_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (ser_clk),
        .sen  (ser_en),
        .sdi  (ser_din),
        .evt  (evt)
    );

    ser_frame u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .rd_word(rd_word),
        .rd_addr(rd_addr),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bit_cnt(bit_cnt),
        .sdo    (ser_dout)
    );

    ser_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_word(rd_word),
        .regs   (regs)
    );
endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk
    import ser_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ser_dout,
    input pin_evt_t                         evt,
    input logic                             wr_en,
    input logic [CNT_W-1:0]                 bit_cnt,
    input logic [DATA_W-1:0]                wr_data,
    input logic [REG_COUNT-1:0][DATA_W-1:0] regs
);
    // R1
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (regs[0] == reg_default(0)) &&
                   (regs[REG_COUNT-1] == reg_default(REG_COUNT-1)));

    // R8
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.en |=> !ser_dout);

    // R7
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dout) |-> ($past(evt.fall) || $past(!evt.en)));

    // R3
    commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!evt.en && $past(evt.en)));

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bit_cnt == CNT_W'(HDR_BITS)) |-> (wr_data == '0));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
endmodule

bind ser_reg_port ser_reg_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_dout(ser_dout),
    .evt     (evt),
    .wr_en   (wr_en),
    .bit_cnt (bit_cnt),
    .wr_data (wr_data),
    .regs    (regs)
);

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;
    import ser_pkg::*;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;

    int tests = 0;
    int fails = 0;
    logic [63:0] cap;
    logic        hdr_bad;
    logic [DATA_W-1:0] model [REG_COUNT];

    always #10 clk = ~clk;

    ser_reg_port u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_en  (ser_en),
        .ser_din (ser_din),
        .ser_dout(ser_dout)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, input logic capture, input logic quiet);
        ser_din = b;
        step(HALF);
        if (capture) cap = {cap[62:0], ser_dout};
        if (quiet && ser_dout !== 1'b0) hdr_bad = 1'b1;
        ser_clk = 1'b1;
        step(HALF);
        ser_clk = 1'b0;
    endtask

    // nhdr header bits of {cmd, addr}, then n data bits taken from d[n-1:0]
    task automatic do_frame(input logic rd, input logic [8:0] a, input logic [63:0] d,
                            input int nhdr, input int n);
        logic [9:0] h;
        h = {rd, a};
        cap = '0;
        hdr_bad = 1'b0;
        ser_en = 1'b1;
        step(HALF);
        for (int k = 0; k < nhdr; k++) clk_bit(h[9-k], 1'b0, 1'b1);
        for (int k = 0; k < n; k++) clk_bit(d[n-1-k], 1'b1, !rd);
        step(HALF);
        ser_en = 1'b0;
        step(2 * HALF);
    endtask

    task automatic wr(input logic [8:0] a, input logic [63:0] d, input int n);
        do_frame(1'b0, a, d, 10, n);
    endtask

    task automatic rd_reg(input logic [8:0] a, output logic [DATA_W-1:0] v);
        do_frame(1'b1, a, 64'd0, 10, DATA_W);
        v = cap[DATA_W-1:0];
    endtask

    task automatic check_bank(input string req);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < REG_COUNT; i++) begin
            rd_reg(BANK_BASE + 9'(i), v);
            chk(req, 64'(v), 64'(model[i]));
        end
    endtask

    initial begin
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] v2;
        step(5);
        // R8: output low in reset
        chk("R8 reset", 64'(ser_dout), 64'd0);
        rst_n = 1'b1;
        step(4);

        // R1: defaults after reset
        for (int i = 0; i < REG_COUNT; i++) model[i] = DATA_W'(32'h50 + i);
        check_bank("R1 default");

        // R2/R3/R4: sweep of every data length on every register
        for (int i = 0; i < REG_COUNT; i++) begin
            for (int n = 0; n <= DATA_W; n++) begin
                logic [DATA_W-1:0] pat;
                logic [DATA_W-1:0] msk;
                pat = DATA_W'(32'h0A5C3F1 * (i + 1) + n * 32'h013579B);
                msk = DATA_W'((64'd1 << n) - 64'd1);
                wr(BANK_BASE + 9'(i), 64'(pat), n);
                chk("R8 write frame sdo", 64'(hdr_bad), 64'd0);
                model[i] = pat & msk;
                rd_reg(BANK_BASE + 9'(i), v);
                if (n == DATA_W) chk("R3 full write", 64'(v), 64'(model[i]));
                else             chk("R4 short write", 64'(v), 64'(model[i]));
                chk("R2 header quiet", 64'(hdr_bad), 64'd0);
            end
        end

        // R5: 32 data bits, first 28 kept
        wr(BANK_BASE + 9'd1, 64'hABCDEF12, 32);
        model[1] = 28'hABCDEF1;
        rd_reg(BANK_BASE + 9'd1, v);
        chk("R5 extra bits", 64'(v), 64'(model[1]));

        // R6: aborted frames
        wr(BANK_BASE + 9'd2, 64'h1234567, 28);
        model[2] = 28'h1234567;
        do_frame(1'b0, BANK_BASE + 9'd2, 64'd0, 6, 0);
        do_frame(1'b0, BANK_BASE + 9'd2, 64'd0, 9, 0);
        do_frame(1'b0, BANK_BASE + 9'd2, 64'd0, 0, 0);
        do_frame(1'b1, BANK_BASE + 9'd2, 64'd0, 7, 0);
        check_bank("R6 abort");

        // R9: out-of-range addresses
        wr(9'h1C4, 64'hFFFFFFF, 28);
        wr(9'h0C0, 64'h0F0F0F0, 28);
        check_bank("R9 write ignored");
        do_frame(1'b1, 9'h1C4, 64'd0, 10, DATA_W);
        chk("R9 read zero", cap, 64'd0);
        do_frame(1'b1, 9'h0C1, 64'd0, 10, DATA_W);
        chk("R9 read zero low", cap, 64'd0);

        // R10: repeated reads give the same word, bank unchanged
        rd_reg(BANK_BASE + 9'd2, v);
        rd_reg(BANK_BASE + 9'd2, v2);
        chk("R10 read twice", 64'(v2), 64'(v));
        check_bank("R10 bank");

        // R7: MSB-first with low tail after 28 bits
        do_frame(1'b1, BANK_BASE + 9'd1, 64'd0, 10, 32);
        chk("R7 tail", cap, {28'd0, model[1], 4'd0});
        chk("R8 after read", 64'(ser_dout), 64'd0);

        // R1: reset after writes restores defaults
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(4);
        for (int i = 0; i < REG_COUNT; i++) model[i] = DATA_W'(32'h50 + i);
        check_bank("R1 reset again");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule